// File: doc/BRIEF.md
# Half-Duplex Transmit Attempt Controller

This block runs the attempts needed to send one frame on a shared half-duplex medium. A frame request starts a deferral phase: the controller holds off while carrier is sensed, then raises its transmit enable. A collision seen early in an attempt ends that attempt. The controller then waits a pseudo-random number of slot times, defers again and retries. It gives up after a fixed number of collisions, or after the first one when retries are disabled. It also gives up on a collision that arrives after the collision window, and on a deferral that lasts too long when the deferral limit is enabled.

While a frame is in progress the controller watches carrier sense to detect carrier loss and missing carrier. It also gathers error flags raised by neighbouring blocks. When the frame ends, it pulses `done` for one cycle and presents a 16-bit status word. The word holds the collision count, one bit per condition, and an error summary. The serialiser reports the end of the data with `frame_end`. All lengths are counted in byte-time ticks supplied on `byte_tick`.

Top module: `hdx_retry_ctrl`

## Requirements
- R1: During and after reset, `tx_en`, `backoff_act` and `done` are 0 and `status` is all zero.
- R2: After a request is accepted, `tx_en` stays 0 for as long as `crs` is high. `tx_en` rises in the cycle after the first cycle with `crs` low. Waiting on carrier sets the deferred bit, `status[4]`.
- R3: A collision while `tx_en` is high, with fewer than LATE_WIN byte ticks elapsed in the attempt, drops `tx_en` and raises `backoff_act` in the next cycle. The controller then defers and retries. `status[3:0]` reports the low four bits of the number of such collisions on the frame.
- R4: The backoff after collision n lasts d·SLOT_BYTES byte ticks plus two cycles, where d is a pseudo-random value from 0 to 2^min(n,BACKOFF_CAP)−1.
- R5: The MAX_ATTEMPTS-th in-window collision (16 by default) ends the frame without a retry and sets the excessive-collision bit, `status[5]`.
- R6: When `retry_dis` is high at request time, the first in-window collision ends the frame and sets `status[5]`.
- R7: A collision after LATE_WIN or more byte ticks of the attempt ends the frame and sets the late-collision bit, `status[6]`. This bit is forced to 0 when the underflow bit is also reported.
- R8: When `defer_chk_en` is high at request time, the frame ends with the excessive-deferral bit, `status[7]`, once DEFER_LIMIT byte ticks have been spent deferring on carrier. With the check disabled, deferral may last any length.
- R9: The loss-of-carrier bit, `status[8]`, is set when `crs` was seen high during an attempt and then went low during that attempt, on a frame that had no collision.
- R10: The no-carrier bit, `status[9]`, is set when `crs` was never high in any transmit cycle of a frame that transmitted at all.
- R11: Each of `err_underflow`, `err_jabber`, `err_flush`, `err_ip_hdr` and `err_ip_pay` seen high in any cycle from acceptance to completion sets a bit of the status word. The bits are 10, 11, 12, 13 and 14, in that order.
- R12: `status[15]` is the OR of status bits 5 to 14.
- R13: `done` is a single-cycle pulse. `status` changes only with `done` and holds its value until the next frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_tick | input | 1 | One pulse per byte time on the medium |
| tx_req | input | 1 | Start a frame (accepted while idle) |
| frame_end | input | 1 | Serialiser has sent the last byte |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision detect |
| retry_dis | input | 1 | Abort on the first collision (sampled at request) |
| defer_chk_en | input | 1 | Enable the deferral limit (sampled at request) |
| err_jabber | input | 1 | Jabber timeout from the transmitter |
| err_flush | input | 1 | Frame flushed by software |
| err_underflow | input | 1 | Data arrived late from memory |
| err_ip_hdr | input | 1 | IP header checksum error |
| err_ip_pay | input | 1 | IP payload checksum error |
| tx_en | output | 1 | Transmit attempt in progress |
| backoff_act | output | 1 | Waiting out a collision backoff |
| done | output | 1 | Frame completed (one cycle) |
| status | output | 16 | Completion status word |

## Verification
The hardest state to reach from the ports is the final collision of a sixteen-attempt frame. Every earlier attempt must see an in-window collision, and each must get through a backoff whose length depends on the pseudo-random draw. The stimulus therefore reacts to the design: it waits for `tx_en`, raises carrier, injects a collision a few ticks later and repeats. A narrow slot setting keeps the wait short. The late-collision boundary is probed with collisions at the last in-window tick and at the first late tick. Deferral is probed by holding carrier past the limit with the check both enabled and disabled.

// File: rtl/hdx_pkg.sv
// Shared types for the half-duplex transmit attempt controller.
package hdx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DEFER   = 2'd1,
        ST_XMIT    = 2'd2,
        ST_BACKOFF = 2'd3
    } hdx_state_e;

    // Completion word; the first member is the most significant bit.
    typedef struct packed {
        logic       err_sum;
        logic       ip_pay;
        logic       ip_hdr;
        logic       flushed;
        logic       jabber;
        logic       underflow;
        logic       no_carrier;
        logic       loss_carrier;
        logic       exc_defer;
        logic       late_coll;
        logic       exc_coll;
        logic       deferred;
        logic [3:0] coll_cnt;
    } hdx_status_t;

endpackage

// File: rtl/hdx_lfsr.sv
// Free-running Galois LFSR used as the source of backoff draws.
// Assumes SEED is non-zero and TAPS describes a maximal polynomial for W.
module hdx_lfsr #(
    parameter int          W     = 16,
    parameter int          OUT_W = 10,
    parameter logic [W-1:0] SEED = 16'hACE1,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);

    logic [W-1:0] q;

    // Advance one step every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= SEED;
        else if (q[0]) q <= (q >> 1) ^ TAPS;
        else q <= q >> 1;
    end

    assign rnd = q[OUT_W-1:0];

endmodule

// File: rtl/hdx_backoff.sv
// Backoff timer: on start, draws a slot count masked to
// 2^min(attempt_n,CAP)-1 and counts it down in units of SLOT_BYTES ticks.
// Assumes start is only pulsed while the timer is idle.
module hdx_backoff #(
    parameter int SLOT_BYTES = 64,
    parameter int CAP        = 10,
    parameter int ATT_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ATT_W-1:0] attempt_n,
    input  logic [CAP-1:0]   rnd,
    input  logic             byte_tick,
    output logic             busy
);

    localparam int SUB_W = (SLOT_BYTES > 1) ? $clog2(SLOT_BYTES) : 1;

    logic [CAP-1:0]   mask;
    logic [CAP-1:0]   slots_q;
    logic [SUB_W-1:0] sub_q;

    // Mask bit i is kept when the attempt number exceeds i (caps at CAP bits).
    always_comb begin
        mask = '0;
        for (int i = 0; i < CAP; i++) mask[i] = (attempt_n > ATT_W'(i));
    end

    // Load the draw on start, then count slots down on byte ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            slots_q <= '0;
            sub_q   <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            slots_q <= rnd & mask;
            sub_q   <= '0;
        end else if (busy && byte_tick) begin
            if (slots_q == '0) begin
                busy <= 1'b0;
            end else if (sub_q == SUB_W'(SLOT_BYTES - 1)) begin
                sub_q   <= '0;
                slots_q <= slots_q - 1'b1;
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end

    a_r4_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/hdx_carrier_mon.sv
// Carrier monitor for one frame: records whether carrier was seen in any
// transmit cycle, whether it dropped after being seen within an attempt,
// and whether any transmit cycle happened. Outputs include the current cycle.
module hdx_carrier_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_clr,
    input  logic attempt_clr,
    input  logic active,
    input  logic crs,
    output logic seen,
    output logic lost,
    output logic tried
);

    logic seen_q, lost_q, tried_q, att_q;
    logic lost_now;

    assign lost_now = active && att_q && !crs;
    assign seen     = seen_q | (active & crs);
    assign lost     = lost_q | lost_now;
    assign tried    = tried_q | active;

    // Sticky per-frame flags, with a per-attempt carrier-seen flag.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_clr) begin
            seen_q  <= 1'b0;
            lost_q  <= 1'b0;
            tried_q <= 1'b0;
            att_q   <= 1'b0;
        end else begin
            if (attempt_clr) att_q <= 1'b0;
            else if (active && crs) att_q <= 1'b1;
            if (active && crs) seen_q <= 1'b1;
            if (lost_now) lost_q <= 1'b1;
            if (active) tried_q <= 1'b1;
        end
    end

    a_r9_lost_after_seen: assert property (@(posedge clk) disable iff (!rst_n)
        lost_q |-> seen_q);

endmodule

// File: rtl/hdx_retry_ctrl.sv
// Half-duplex transmit attempt controller. Runs defer / transmit / backoff
// for one frame at a time and reports a status word on completion.
// Assumes byte_tick marks byte times, frame_end comes from the serialiser
// while tx_en is high, and mode inputs are stable at request time.
module hdx_retry_ctrl
    import hdx_pkg::*;
#(
    parameter int SLOT_BYTES   = 64,
    parameter int LATE_WIN     = 64,
    parameter int MAX_ATTEMPTS = 16,
    parameter int BACKOFF_CAP  = 10,
    parameter int DEFER_LIMIT  = 3036,
    parameter int RAND_W       = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_tick,
    input  logic        tx_req,
    input  logic        frame_end,
    input  logic        crs,
    input  logic        col,
    input  logic        retry_dis,
    input  logic        defer_chk_en,
    input  logic        err_jabber,
    input  logic        err_flush,
    input  logic        err_underflow,
    input  logic        err_ip_hdr,
    input  logic        err_ip_pay,
    output logic        tx_en,
    output logic        backoff_act,
    output logic        done,
    output logic [15:0] status
);

    localparam int ATT_W = $clog2(MAX_ATTEMPTS + 1);
    localparam int WIN_W = $clog2(LATE_WIN + 1);
    localparam int DEF_W = $clog2(DEFER_LIMIT + 1);

    hdx_state_e       state_q, state_d;
    logic [ATT_W-1:0] coll_q, coll_inc;
    logic [WIN_W-1:0] win_q;
    logic [DEF_W-1:0] def_q;
    logic             deferred_q, rd_q, chk_q, done_q;
    logic [4:0]       ext_q, ext_in, ext_now;
    hdx_status_t      stat_q, stat_d;

    logic in_idle, in_defer, in_xmit, in_bo;
    logic accept, late_hit, early_col, exc_hit, bo_start;
    logic defer_hit, go_xmit, ok_end, finish;
    logic [3:0] coll_field;
    logic cm_seen, cm_lost, cm_tried, bo_busy;
    logic [BACKOFF_CAP-1:0] rnd;

    assign in_idle  = (state_q == ST_IDLE);
    assign in_defer = (state_q == ST_DEFER);
    assign in_xmit  = (state_q == ST_XMIT);
    assign in_bo    = (state_q == ST_BACKOFF);

    assign ext_in  = {err_ip_pay, err_ip_hdr, err_flush, err_jabber, err_underflow};
    assign ext_now = ext_q | ext_in;

    // Frame events decoded from the current state and inputs.
    assign accept     = in_idle & tx_req;
    assign coll_inc   = coll_q + 1'b1;
    assign late_hit   = in_xmit & col & (win_q >= WIN_W'(LATE_WIN));
    assign early_col  = in_xmit & col & ~late_hit;
    assign exc_hit    = early_col & (rd_q | (coll_inc == ATT_W'(MAX_ATTEMPTS)));
    assign bo_start   = early_col & ~exc_hit;
    assign defer_hit  = in_defer & chk_q & (def_q >= DEF_W'(DEFER_LIMIT));
    assign go_xmit    = in_defer & ~defer_hit & ~crs;
    assign ok_end     = in_xmit & ~col & frame_end;
    assign finish     = late_hit | exc_hit | defer_hit | ok_end;
    assign coll_field = early_col ? coll_inc[3:0] : coll_q[3:0];

    hdx_lfsr #(.W(RAND_W), .OUT_W(BACKOFF_CAP)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .rnd(rnd)
    );

    hdx_backoff #(.SLOT_BYTES(SLOT_BYTES), .CAP(BACKOFF_CAP), .ATT_W(ATT_W)) u_backoff (
        .clk(clk), .rst_n(rst_n), .start(bo_start), .attempt_n(coll_inc),
        .rnd(rnd), .byte_tick(byte_tick), .busy(bo_busy)
    );

    hdx_carrier_mon u_cmon (
        .clk(clk), .rst_n(rst_n), .frame_clr(accept), .attempt_clr(go_xmit),
        .active(in_xmit), .crs(crs), .seen(cm_seen), .lost(cm_lost), .tried(cm_tried)
    );

    // Next-state selection for the attempt sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = ST_DEFER;
            ST_DEFER:   if (defer_hit) state_d = ST_IDLE;
                        else if (go_xmit) state_d = ST_XMIT;
            ST_XMIT:    if (finish) state_d = ST_IDLE;
                        else if (bo_start) state_d = ST_BACKOFF;
            ST_BACKOFF: if (!bo_busy) state_d = ST_DEFER;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Completion word assembled in the finishing cycle.
    always_comb begin
        stat_d              = '0;
        stat_d.coll_cnt     = coll_field;
        stat_d.deferred     = deferred_q;
        stat_d.exc_coll     = exc_hit;
        stat_d.late_coll    = late_hit & ~ext_now[0];
        stat_d.exc_defer    = defer_hit;
        stat_d.loss_carrier = cm_lost & (coll_q == '0) & ~(in_xmit & col);
        stat_d.no_carrier   = cm_tried & ~cm_seen;
        stat_d.underflow    = ext_now[0];
        stat_d.jabber       = ext_now[1];
        stat_d.flushed      = ext_now[2];
        stat_d.ip_hdr       = ext_now[3];
        stat_d.ip_pay       = ext_now[4];
        stat_d.err_sum      = |{stat_d.ip_pay, stat_d.ip_hdr, stat_d.flushed,
                                stat_d.jabber, stat_d.underflow, stat_d.no_carrier,
                                stat_d.loss_carrier, stat_d.exc_defer,
                                stat_d.late_coll, stat_d.exc_coll};
    end

    // State register and per-frame mode capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rd_q    <= 1'b0;
            chk_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                rd_q  <= retry_dis;
                chk_q <= defer_chk_en;
            end
        end
    end

    // Collision, window and deferral counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coll_q     <= '0;
            win_q      <= '0;
            def_q      <= '0;
            deferred_q <= 1'b0;
        end else begin
            if (accept) coll_q <= '0;
            else if (early_col) coll_q <= coll_inc;
            if (go_xmit) win_q <= '0;
            else if (in_xmit && byte_tick && win_q < WIN_W'(LATE_WIN)) win_q <= win_q + 1'b1;
            if (accept) def_q <= '0;
            else if (in_defer && crs && byte_tick && def_q < DEF_W'(DEFER_LIMIT)) def_q <= def_q + 1'b1;
            if (accept) deferred_q <= 1'b0;
            else if (in_defer && crs) deferred_q <= 1'b1;
        end
    end

    // Sticky neighbour error flags over the life of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= '0;
        else if (accept) ext_q <= ext_in;
        else if (!in_idle) ext_q <= ext_now;
    end

    // Completion pulse and held status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            stat_q <= '0;
        end else begin
            done_q <= finish;
            if (finish) stat_q <= stat_d;
        end
    end

    assign tx_en       = in_xmit;
    assign backoff_act = in_bo;
    assign done        = done_q;
    assign status      = stat_q;

    a_r3_col_ends_attempt: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && col) |=> !tx_en);

    a_r2_wait_on_carrier: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEFER && crs) |=> !tx_en);

    a_r13_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_coll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        coll_q <= ATT_W'(MAX_ATTEMPTS));

    a_r10_nc_excludes_loc: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(stat_q.no_carrier && stat_q.loss_carrier));

endmodule

// File: tb/tb_hdx_retry_ctrl.sv
module tb_hdx_retry_ctrl;

    localparam int SLOT  = 2;
    localparam int LATE  = 64;
    localparam int LIMIT = 3036;
    localparam int MAXC  = 16;
    localparam int CAP   = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic byte_tick = 1'b1, tx_req = 1'b0, frame_end = 1'b0, crs = 1'b0, col = 1'b0;
    logic retry_dis = 1'b0, defer_chk_en = 1'b0;
    logic err_jabber = 1'b0, err_flush = 1'b0, err_underflow = 1'b0;
    logic err_ip_hdr = 1'b0, err_ip_pay = 1'b0;
    logic tx_en, backoff_act, done;
    logic [15:0] status;

    always #4 clk = ~clk;

    hdx_retry_ctrl #(.SLOT_BYTES(SLOT)) dut (
        .clk(clk), .rst_n(rst_n), .byte_tick(byte_tick), .tx_req(tx_req),
        .frame_end(frame_end), .crs(crs), .col(col), .retry_dis(retry_dis),
        .defer_chk_en(defer_chk_en), .err_jabber(err_jabber), .err_flush(err_flush),
        .err_underflow(err_underflow), .err_ip_hdr(err_ip_hdr), .err_ip_pay(err_ip_pay),
        .tx_en(tx_en), .backoff_act(backoff_act), .done(done), .status(status)
    );

    int n_checks = 0, n_fail = 0;

    // Reference model state (0 idle, 1 defer, 2 transmit, 3 backoff).
    int   m_st = 0, m_coll = 0, m_win = 0, m_def = 0, m_bo = 0;
    bit   m_deferred, m_seen, m_seen_att, m_lost, m_tried, m_rd, m_chk, m_done, m_edge;
    logic [4:0]  m_ext;
    logic [15:0] m_status = '0;
    bit   bo_low = 1'b0;

    task automatic finish_frame(input int kind); // 0 ok, 1 exc, 2 late, 3 defer
        logic [15:0] s;
        s = '0;
        s[3:0] = m_coll[3:0];
        s[4]  = m_deferred;
        s[5]  = (kind == 1);
        s[6]  = (kind == 2) && !m_ext[0];
        s[7]  = (kind == 3);
        s[8]  = m_lost && (m_coll == 0) && (kind != 2);
        s[9]  = m_tried && !m_seen;
        s[14:10] = m_ext;
        s[15] = |s[14:5];
        m_status = s;
        m_done = 1'b1;
        m_st = 0;
    endtask

    task automatic model_defer();
        if (m_chk && m_def >= LIMIT) finish_frame(3);
        else if (crs) begin
            m_deferred = 1'b1;
            if (byte_tick && m_def < LIMIT) m_def++;
        end else begin
            m_st = 2; m_win = 0; m_seen_att = 1'b0;
        end
    endtask

    task automatic model_xmit();
        m_tried = 1'b1;
        if (m_seen_att && !crs) m_lost = 1'b1;
        if (crs) begin m_seen_att = 1'b1; m_seen = 1'b1; end
        if (col) begin
            if (m_win >= LATE) finish_frame(2);
            else begin
                m_coll++;
                if (m_rd || m_coll == MAXC) finish_frame(1);
                else begin m_st = 3; m_bo = 0; end
            end
        end else if (frame_end) finish_frame(0);
        else if (byte_tick && m_win < LATE) m_win++;
    endtask

    // Cycle model, advanced on every rising edge from the sampled inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_coll = 0; m_done = 1'b0; m_status = '0; m_edge = 1'b1;
        end else begin
            m_done = 1'b0;
            if (m_st != 0)
                m_ext = m_ext | {err_ip_pay, err_ip_hdr, err_flush, err_jabber, err_underflow};
            case (m_st)
                0: if (tx_req) begin
                    m_st = 1; m_coll = 0; m_def = 0; m_deferred = 1'b0;
                    m_seen = 1'b0; m_lost = 1'b0; m_tried = 1'b0; m_seen_att = 1'b0;
                    m_ext = {err_ip_pay, err_ip_hdr, err_flush, err_jabber, err_underflow};
                    m_rd = retry_dis; m_chk = defer_chk_en;
                end
                1: model_defer();
                2: model_xmit();
                default: if (bo_low) begin m_st = 1; model_defer(); end
                         else m_bo++;
            endcase
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare the design against the model away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            if (m_edge) begin
                check("R1 reset tx_en", int'(tx_en), 0);
                check("R1 reset backoff_act", int'(backoff_act), 0);
                check("R1 reset done", int'(done), 0);
                check("R1 reset status", int'(status), 0);
            end
        end else begin
            bo_low = (m_st == 3) && !backoff_act;
            if (bo_low) begin
                int k;
                k = (m_coll < CAP) ? m_coll : CAP;
                check("R4 backoff within range", int'(m_bo <= ((1 << k) - 1) * SLOT + 2), 1);
                check("R4 backoff minimum", int'(m_bo >= 2), 1);
            end
            check("R2 tx_en", int'(tx_en), int'(m_st == 2));
            check("R3 backoff_act", int'(backoff_act), int'(m_st == 3 && !bo_low));
            check("R13 done", int'(done), int'(m_done));
            check("R13 status held", int'(status), int'(m_status));
            if (m_done) begin
                check("R3 collision count", int'(status[3:0]), int'(m_status[3:0]));
                check("R2 deferred bit", int'(status[4]), int'(m_status[4]));
                check(m_rd ? "R6 abort on first collision" : "R5 excessive collision",
                      int'(status[5]), int'(m_status[5]));
                check("R7 late collision", int'(status[6]), int'(m_status[6]));
                check("R8 excessive deferral", int'(status[7]), int'(m_status[7]));
                check("R9 loss of carrier", int'(status[8]), int'(m_status[8]));
                check("R10 no carrier", int'(status[9]), int'(m_status[9]));
                check("R11 neighbour errors", int'(status[14:10]), int'(m_status[14:10]));
                check("R12 error summary", int'(status[15]), int'(m_status[15]));
            end
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic idle(input int n);
        repeat (n) step();
    endtask

    task automatic start_frame(input bit rd, input bit chk);
        retry_dis = rd; defer_chk_en = chk; tx_req = 1'b1;
        step();
        tx_req = 1'b0;
    endtask

    task automatic wait_tx();
        for (int i = 0; i < 20000 && !tx_en; i++) step();
    endtask

    task automatic end_frame();
        frame_end = 1'b1; step(); frame_end = 1'b0; crs = 1'b0;
        idle(4);
    endtask

    task automatic collide();
        col = 1'b1; step(); col = 1'b0; crs = 1'b0;
    endtask

    task automatic report(input int extra);
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks + extra, n_fail + extra);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R2: clean frame, then one that waits on carrier
        start_frame(0, 0); wait_tx(); crs = 1'b1; idle(20); end_frame();
        crs = 1'b1; start_frame(0, 0); idle(30); crs = 1'b0;
        wait_tx(); crs = 1'b1; idle(10); end_frame();
        // R3 R4: three in-window collisions, then success
        start_frame(0, 0);
        for (int i = 0; i < 3; i++) begin wait_tx(); crs = 1'b1; idle(5); collide(); end
        wait_tx(); crs = 1'b1; idle(5); end_frame();
        // R5: collisions until the frame is abandoned
        start_frame(0, 0);
        for (int i = 0; i < MAXC; i++) begin wait_tx(); crs = 1'b1; idle(3); collide(); end
        idle(6);
        // R6: retry disabled
        start_frame(1, 0); wait_tx(); crs = 1'b1; idle(3); collide(); idle(6);
        // R7: last in-window tick, then first late tick
        start_frame(0, 0); wait_tx(); crs = 1'b1; idle(LATE - 1); collide();
        wait_tx(); crs = 1'b1; idle(LATE); collide(); idle(6);
        // R7: late collision hidden by underflow
        start_frame(0, 0); wait_tx(); crs = 1'b1;
        err_underflow = 1'b1; step(); err_underflow = 1'b0;
        idle(70); collide(); idle(6);
        // R8: deferral limit enabled, then disabled
        crs = 1'b1; start_frame(0, 1); idle(LIMIT + 60); crs = 1'b0; idle(6);
        crs = 1'b1; start_frame(0, 0); idle(LIMIT + 60); crs = 1'b0;
        wait_tx(); crs = 1'b1; idle(5); end_frame();
        // R9: carrier drops mid-frame
        start_frame(0, 0); wait_tx(); crs = 1'b1; idle(5); crs = 1'b0; idle(2);
        crs = 1'b1; idle(5); end_frame();
        // R10: no carrier at all
        start_frame(0, 0); wait_tx(); idle(10); end_frame();
        // R11 R12: neighbour errors during deferral and transmission
        crs = 1'b1; start_frame(0, 0);
        err_flush = 1'b1; step(); err_flush = 1'b0;
        err_ip_pay = 1'b1; step(); err_ip_pay = 1'b0;
        crs = 1'b0; wait_tx(); crs = 1'b1;
        err_jabber = 1'b1; step(); err_jabber = 1'b0;
        err_ip_hdr = 1'b1; step(); err_ip_hdr = 1'b0;
        idle(5); end_frame();
        // R13: status holds through idle time
        idle(20);
        report(0);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog: actual=timeout expected=completion");
        report(1);
        $finish;
    end

endmodule